// File: doc/BRIEF.md
# Warp Lane Divergence Mask Controller

This block keeps track of which of the 32 lanes of one warp are enabled while the warp runs through two-way branches. When a branch arrives with a per-lane condition vector, the lanes that are currently enabled and whose condition is true run the first path. The enabled lanes whose condition is false run the second path afterwards. When the reconvergence marker arrives, every lane that was enabled before the branch is enabled again. A stack of saved masks lets branches nest.

The instruction sequencer drives three event inputs: a branch strobe with its condition vector, an else marker at the start of the second path, and a reconvergence marker at the join point. The block returns the lane-enable mask and a per-lane write-enable vector for the register file. If a path would run on no lanes at all, the block raises a one-cycle skip pulse and moves straight on. After a skip at the branch, the sequencer jumps past the else marker. After a skip at the else marker, it jumps past the reconvergence marker. A branch that arrives while the stack is full is dropped and sets a sticky overflow flag.

Top module: `lane_div_top`

## Requirements
- R1: After reset `laneEn` is all ones, `pathSkip` and `overflowErr` are 0, and the stack is empty.
- R2: A branch whose taken mask (`laneEn & cond`) is non-zero makes `laneEn` equal to that taken mask from the cycle after the branch strobe.
- R3: An else marker makes `laneEn` equal to the saved pre-branch mask AND NOT the branch condition, provided that mask is non-zero.
- R4: A reconvergence marker restores the mask that was in force just before the matching branch, and closes that nesting level.
- R5: A branch whose taken mask is zero pulses `pathSkip` high for one cycle and puts the else mask on `laneEn` at once. That level then waits only for its reconvergence marker.
- R6: An else marker whose else mask is zero pulses `pathSkip` for one cycle, restores the pre-branch mask and closes the level. No reconvergence marker is consumed for it.
- R7: Branches nest up to 8 levels deep. Each reconvergence marker restores the mask of the innermost open level.
- R8: A branch that arrives with 8 levels open is dropped, so `laneEn` and the stack are unchanged. It sets `overflowErr`, which stays 1 until reset.
- R9: `laneWe` equals `laneEn` bit for bit while `wrValid` is 1 and is all zeros while `wrValid` is 0. A lane whose enable bit is clear never gets a write enable.
- R10: A reconvergence marker with no open level, and an else marker whose innermost level is already in its second path, have no effect. Without events, `laneEn` holds.
- R11: A branch never enables a lane that was disabled before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| branchValid | input | 1 | Branch event strobe, qualifies `cond` |
| cond | input | 32 | Per-lane branch condition, bit i for lane i |
| elseMark | input | 1 | Start of the second path of the innermost branch |
| reconvMark | input | 1 | Join point of the innermost branch |
| wrValid | input | 1 | Current instruction writes lane registers |
| laneEn | output | 32 | Lane-enable mask, bit i enables lane i |
| laneWe | output | 32 | Per-lane register write enable |
| pathSkip | output | 1 | One-cycle pulse: the path just reached has no lanes and is skipped |
| overflowErr | output | 1 | Sticky flag: a branch was dropped because the stack was full |

## Verification
The assertions assume that at most one of the three event strobes is high in any cycle. They also assume the sequencer follows the skip protocol, so an else marker is never sent for a level that was skipped at its branch. The stimulus table and the directed sequences issue exactly one event per step, with idle cycles in between. After every skip pulse they jump past the marker that the skip consumed, which is the same jump a real sequencer would make. The only markers sent out of protocol are the ones R10 says must be ignored, and those cases are observed at `laneEn`.

// File: rtl/lane_div_pkg.sv
package lane_div_pkg;

  localparam int unsigned LANES_DEF = 32;
  localparam int unsigned DEPTH_DEF = 8;

  // Strobes from the sequencing control to the mask datapath
  typedef struct packed {
    logic push;           // open a nesting level
    logic pop;            // close the innermost level
    logic selTaken;       // active <= active & cond
    logic selBranchElse;  // active <= active & ~cond (taken path empty)
    logic selTopElse;     // active <= stored else mask of innermost level
    logic selSaved;       // active <= stored pre-branch mask
    logic markElse;       // innermost level enters its second path
    logic skip;           // raise the skip pulse
    logic ovf;            // branch dropped, stack full
  } ctrlStrobes_t;

endpackage

// File: rtl/lane_div_ctrl.sv
module lane_div_ctrl
  import lane_div_pkg::*;
(
  input  logic         branchValid,
  input  logic         elseMark,
  input  logic         reconvMark,
  input  logic         stackEmpty,
  input  logic         stackFull,
  input  logic         topIsElse,
  input  logic         takenZero,
  input  logic         topElseZero,
  output ctrlStrobes_t strobes
);

  // Events are decoded with reconvergence first, then else, then branch.
  always_comb begin
    strobes = '0;
    if (reconvMark) begin
      if (!stackEmpty) begin
        strobes.pop      = 1'b1;
        strobes.selSaved = 1'b1;
      end
    end else if (elseMark) begin
      if (!stackEmpty && !topIsElse) begin
        if (topElseZero) begin
          strobes.skip     = 1'b1;
          strobes.pop      = 1'b1;
          strobes.selSaved = 1'b1;
        end else begin
          strobes.markElse   = 1'b1;
          strobes.selTopElse = 1'b1;
        end
      end
    end else if (branchValid) begin
      if (stackFull) begin
        strobes.ovf = 1'b1;
      end else begin
        strobes.push = 1'b1;
        if (takenZero) begin
          strobes.selBranchElse = 1'b1;
          strobes.skip          = 1'b1;
        end else begin
          strobes.selTaken = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lane_div_dpath.sv
module lane_div_dpath
  import lane_div_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [LANES-1:0] cond,
  input  logic             wrValid,
  output logic [LANES-1:0] laneEn,
  output logic [LANES-1:0] laneWe,
  output logic             pathSkip,
  output logic             overflowErr,
  output logic             stackEmpty,
  output logic             stackFull,
  output logic             topIsElse,
  output logic             takenZero,
  output logic             topElseZero
);

  localparam int unsigned SP_W  = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] activeQ;
  logic [LANES-1:0] savedQ [DEPTH];
  logic [LANES-1:0] elseQ  [DEPTH];
  logic [DEPTH-1:0] phaseQ;
  logic [SP_W-1:0]  spQ;
  logic             skipQ;
  logic             ovfQ;

  logic [LANES-1:0] takenMask;
  logic [LANES-1:0] branchElse;
  logic [IDX_W-1:0] topIdx;
  logic [IDX_W-1:0] pushIdx;
  logic [DEPTH-1:0] pushSel;
  logic [DEPTH-1:0] elseSel;
  logic [LANES-1:0] activeNext;

  assign takenMask  = activeQ & cond;
  assign branchElse = activeQ & ~cond;
  assign pushIdx    = IDX_W'(spQ);
  assign topIdx     = IDX_W'(spQ - SP_W'(1));

  assign stackEmpty  = (spQ == '0);
  assign stackFull   = (spQ == SP_W'(DEPTH));
  assign topIsElse   = !stackEmpty && phaseQ[topIdx];
  assign takenZero   = (takenMask == '0);
  assign topElseZero = (elseQ[topIdx] == '0);

  // Per-entry write selects
  for (genvar e = 0; e < DEPTH; e++) begin : g_sel
    assign pushSel[e] = strobes.push     && (pushIdx == IDX_W'(e));
    assign elseSel[e] = strobes.markElse && (topIdx  == IDX_W'(e));
  end

  always_comb begin
    activeNext = activeQ;
    if (strobes.selTaken)      activeNext = takenMask;
    if (strobes.selBranchElse) activeNext = branchElse;
    if (strobes.selTopElse)    activeNext = elseQ[topIdx];
    if (strobes.selSaved)      activeNext = savedQ[topIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= '1;
      spQ     <= '0;
      phaseQ  <= '0;
      skipQ   <= 1'b0;
      ovfQ    <= 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
        savedQ[e] <= '1;
        elseQ[e]  <= '0;
      end
    end else begin
      activeQ <= activeNext;
      skipQ   <= strobes.skip;
      if (strobes.ovf) ovfQ <= 1'b1;
      if (strobes.push)     spQ <= spQ + SP_W'(1);
      else if (strobes.pop) spQ <= spQ - SP_W'(1);
      for (int e = 0; e < DEPTH; e++) begin
        if (pushSel[e]) begin
          savedQ[e] <= activeQ;
          elseQ[e]  <= branchElse;
          phaseQ[e] <= takenZero;
        end else if (elseSel[e]) begin
          phaseQ[e] <= 1'b1;
        end
      end
    end
  end

  // Per-lane write gating
  for (genvar l = 0; l < LANES; l++) begin : g_we
    assign laneWe[l] = activeQ[l] & wrValid;
  end

  assign laneEn      = activeQ;
  assign pathSkip    = skipQ;
  assign overflowErr = ovfQ;

endmodule

// File: rtl/lane_div_top.sv
module lane_div_top
  import lane_div_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             branchValid,
  input  logic [LANES-1:0] cond,
  input  logic             elseMark,
  input  logic             reconvMark,
  input  logic             wrValid,
  output logic [LANES-1:0] laneEn,
  output logic [LANES-1:0] laneWe,
  output logic             pathSkip,
  output logic             overflowErr
);

  ctrlStrobes_t strobes;
  logic stackEmpty, stackFull, topIsElse, takenZero, topElseZero;

  lane_div_ctrl ctrl_i (
    .branchValid (branchValid),
    .elseMark    (elseMark),
    .reconvMark  (reconvMark),
    .stackEmpty  (stackEmpty),
    .stackFull   (stackFull),
    .topIsElse   (topIsElse),
    .takenZero   (takenZero),
    .topElseZero (topElseZero),
    .strobes     (strobes)
  );

  lane_div_dpath #(.LANES(LANES), .DEPTH(DEPTH)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cond        (cond),
    .wrValid     (wrValid),
    .laneEn      (laneEn),
    .laneWe      (laneWe),
    .pathSkip    (pathSkip),
    .overflowErr (overflowErr),
    .stackEmpty  (stackEmpty),
    .stackFull   (stackFull),
    .topIsElse   (topIsElse),
    .takenZero   (takenZero),
    .topElseZero (topElseZero)
  );

endmodule

// File: rtl/lane_div_chk.sv
module lane_div_chk #(
  parameter int unsigned LANES = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             branchValid,
  input logic             elseMark,
  input logic             reconvMark,
  input logic             wrValid,
  input logic [LANES-1:0] laneEn,
  input logic [LANES-1:0] laneWe,
  input logic             pathSkip,
  input logic             overflowErr
);

  // Input protocol: one event per cycle (R10 relies on it)
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({branchValid, elseMark, reconvMark}));

  // R11: a branch only removes lanes
  p_branch_subset_r11: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |=> ((laneEn & ~$past(laneEn)) == '0));

  // R10: mask holds without events
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(branchValid || elseMark || reconvMark) |=> $stable(laneEn));

  // R5 / R6: a skip pulse follows only a branch or an else marker
  p_skip_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    pathSkip |-> $past(branchValid || elseMark));

  // R6: a skip never follows a reconvergence marker
  p_skip_not_reconv_r6: assert property (@(posedge clk) disable iff (!rstN)
    reconvMark |=> !pathSkip);

  // R8: overflow is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  // R8: a dropped branch leaves the mask alone
  p_ovf_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowErr) |-> (laneEn == $past(laneEn)));

  // R9: no write enable outside the lane mask, none without wrValid
  p_we_inside_r9: assert property (@(posedge clk) disable iff (!rstN)
    (laneWe & ~laneEn) == '0);
  p_we_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> (laneWe == '0));

endmodule

bind lane_div_top lane_div_chk #(.LANES(LANES)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .branchValid (branchValid),
  .elseMark    (elseMark),
  .reconvMark  (reconvMark),
  .wrValid     (wrValid),
  .laneEn      (laneEn),
  .laneWe      (laneWe),
  .pathSkip    (pathSkip),
  .overflowErr (overflowErr)
);

// File: tb/lane_div_top_tb_top.sv
`timescale 1ns/1ps
module lane_div_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        branchValid = 1'b0;
  logic [31:0] cond = '0;
  logic        elseMark = 1'b0;
  logic        reconvMark = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] laneEn, laneWe;
  logic        pathSkip, overflowErr;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lane_div_top dut_i (
    .clk(clk), .rstN(rstN), .branchValid(branchValid), .cond(cond),
    .elseMark(elseMark), .reconvMark(reconvMark), .wrValid(wrValid),
    .laneEn(laneEn), .laneWe(laneWe), .pathSkip(pathSkip),
    .overflowErr(overflowErr)
  );

  // kind: 0 idle, 1 branch, 2 else, 3 reconv | cond | expected laneEn | expected skip
  localparam int NV = 21;
  localparam logic [66:0] VEC [NV] = '{
    {2'd1, 32'h0000FFFF, 32'h0000FFFF, 1'b0},  // R2 outer branch
    {2'd1, 32'h00FF00FF, 32'h000000FF, 1'b0},  // R2 R7 nested branch
    {2'd2, 32'h0,        32'h0000FF00, 1'b0},  // R3 inner else
    {2'd3, 32'h0,        32'h0000FFFF, 1'b0},  // R4 R7 inner join
    {2'd2, 32'h0,        32'hFFFF0000, 1'b0},  // R3 outer else
    {2'd3, 32'h0,        32'hFFFFFFFF, 1'b0},  // R4 outer join
    {2'd1, 32'h00000000, 32'hFFFFFFFF, 1'b1},  // R5 taken empty
    {2'd3, 32'h0,        32'hFFFFFFFF, 1'b0},  // R4 join after skip
    {2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0},  // R2 all taken
    {2'd2, 32'h0,        32'hFFFFFFFF, 1'b1},  // R6 else empty
    {2'd3, 32'h0,        32'hFFFFFFFF, 1'b0},  // R10 join with no level
    {2'd1, 32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0},  // R2
    {2'd0, 32'h0,        32'hAAAAAAAA, 1'b0},  // R10 idle hold
    {2'd2, 32'h0,        32'h55555555, 1'b0},  // R3
    {2'd2, 32'h0,        32'h55555555, 1'b0},  // R10 second else ignored
    {2'd3, 32'h0,        32'hFFFFFFFF, 1'b0},  // R4
    {2'd1, 32'h0F0F0F0F, 32'h0F0F0F0F, 1'b0},  // R2
    {2'd1, 32'h00000000, 32'h0F0F0F0F, 1'b1},  // R5 nested taken empty
    {2'd3, 32'h0,        32'h0F0F0F0F, 1'b0},  // R4 R7
    {2'd2, 32'h0,        32'hF0F0F0F0, 1'b0},  // R3
    {2'd3, 32'h0,        32'hFFFFFFFF, 1'b0}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge: apply event, pass one rising edge, return at next falling edge
  task automatic step(input logic [1:0] kind, input logic [31:0] c, input logic we);
    branchValid = (kind == 2'd1);
    elseMark    = (kind == 2'd2);
    reconvMark  = (kind == 2'd3);
    cond        = c;
    wrValid     = we;
    @(negedge clk);
    branchValid = 1'b0;
    elseMark    = 1'b0;
    reconvMark  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 laneEn", laneEn, 32'hFFFFFFFF);
    chk("R1 skip", {31'b0, pathSkip}, 32'h0);
    chk("R1 ovf", {31'b0, overflowErr}, 32'h0);
    step(2'd3, 32'h0, 1'b0);
    chk("R1 empty stack, join ignored", laneEn, 32'hFFFFFFFF);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic we;
      we = i[0];
      wrValid = we;
      step(VEC[i][66:65], VEC[i][64:33], we);
      chk($sformatf("R2-table step %0d laneEn", i), laneEn, VEC[i][32:1]);
      chk($sformatf("R5 R6 step %0d skip", i), {31'b0, pathSkip}, {31'b0, VEC[i][0]});
      chk($sformatf("R9 step %0d laneWe", i), laneWe, we ? VEC[i][32:1] : 32'h0);
    end

    // Skip pulse lasts one cycle
    step(2'd1, 32'h0, 1'b0);
    chk("R5 skip raised", {31'b0, pathSkip}, 32'h1);
    step(2'd0, 32'h0, 1'b0);
    chk("R5 skip one cycle", {31'b0, pathSkip}, 32'h0);
    step(2'd3, 32'h0, 1'b0);
    chk("R4 close", laneEn, 32'hFFFFFFFF);

    // Fill the stack to 8 levels
    for (int k = 0; k < 8; k++) step(2'd1, ~(32'h1 << k), 1'b0);
    chk("R7 depth 8 mask", laneEn, 32'hFFFFFF00);
    chk("R7 no overflow at 8", {31'b0, overflowErr}, 32'h0);
    step(2'd1, 32'h0000FFFF, 1'b0);
    chk("R8 dropped branch mask", laneEn, 32'hFFFFFF00);
    chk("R8 overflow set", {31'b0, overflowErr}, 32'h1);
    for (int j = 1; j <= 8; j++) begin
      step(2'd3, 32'h0, 1'b0);
      chk($sformatf("R7 unwind %0d", j), laneEn, ~((32'h1 << (8 - j)) - 32'h1));
    end
    step(2'd3, 32'h0, 1'b0);
    chk("R10 extra join ignored", laneEn, 32'hFFFFFFFF);
    chk("R8 overflow sticky", {31'b0, overflowErr}, 32'h1);

    // Reset again
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ovf cleared", {31'b0, overflowErr}, 32'h0);
    chk("R1 laneEn after reset", laneEn, 32'hFFFFFFFF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule